// File: doc/BRIEF.md
# Two-Section Ripple Decade Counter

This block is a four-bit counter split into two sections, each with its own clock. A divide-by-two section produces the low output bit and advances on the falling edge of its clock. An upper section produces the three high output bits and advances on the falling edge of a second clock. Its modulus is fixed at elaboration as five, six or eight. The two sections are cascaded by wiring outside the block. Routing the low bit into the upper clock gives a BCD count in the divide-by-five build, a divide-by-twelve count in the divide-by-six build, and a modulo-16 binary count in the divide-by-eight build. Routing the top output bit back into the low clock, while clocking the upper section, gives a bi-quinary sequence.

Two pairs of control inputs act without a clock. When both clear inputs are high, all outputs go to zero. In the divide-by-five build, when both preset inputs are high, the outputs go to decimal nine. The preset takes priority over the clear.

Top module: `dual_section_counter`

## Requirements
- R1: `out_bit0` inverts on every falling edge of `clk_div2`; a rising edge of `clk_div2` leaves it unchanged.
- R2: `out_hi` changes only on a falling edge of `clk_upper`; edges of `clk_div2` never change it directly.
- R3: In the divide-by-five build, `out_hi` (bit 2 = Q3, bit 1 = Q2, bit 0 = Q1) steps 0,1,2,3,4,0 on successive `clk_upper` falling edges. With `out_bit0` feeding `clk_upper`, the value {out_hi,out_bit0} counts 0 to 9 and then wraps to 0.
- R4: In the divide-by-five build, with `out_hi[2]` feeding `clk_div2` and `clk_upper` clocked, the n-th count (n mod 10) shows `out_hi` = n mod 5 and `out_bit0` = n / 5.
- R5: While `clr_a` and `clr_b` are both high, every output is 0 at once, without waiting for a clock edge; either input alone has no effect.
- R6: In the divide-by-five build, while `nine_a` and `nine_b` are both high, {out_hi,out_bit0} is 4'b1001 at once; either input alone has no effect; the preset wins when the clear is also high.
- R7: Clock edges that arrive while the clear or the preset is active do not change the outputs.
- R8: In the divide-by-six build, `out_hi` steps 000,001,010,100,101,110 and back to 000. With `out_bit0` feeding `clk_upper`, the outputs repeat every 12 `clk_div2` falling edges.
- R9: In the divide-by-eight build, with `out_bit0` feeding `clk_upper`, {out_hi,out_bit0} counts in binary modulo 16.
- R10: In the divide-by-six and divide-by-eight builds, `nine_a` and `nine_b` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_div2 | input | 1 | Falling-edge clock of the divide-by-two section |
| clk_upper | input | 1 | Falling-edge clock of the upper section |
| clr_a | input | 1 | Clear gate, first input |
| clr_b | input | 1 | Clear gate, second input |
| nine_a | input | 1 | Preset-to-nine gate, first input |
| nine_b | input | 1 | Preset-to-nine gate, second input |
| out_bit0 | output | 1 | Divide-by-two section output |
| out_hi | output | 3 | Upper section outputs (bit 2 is the most significant) |

## Verification
The bench cascades the sections externally in each wiring. It follows the BCD wrap from nine to zero, the bi-quinary hand-off where the top bit falling clocks the low section, and the divide-by-six pair wrap that toggles the top bit. A design that counts on the wrong edge, lets the upper section reach five, six or seven, or skips a state in the divide-by-twelve loop would show a wrong value at the step where it goes astray. The bench raises the clear and preset gates one input at a time and then together, with no clock. A design that decodes only one gate input, waits for an edge, or gives the clear priority would show a count, a stale value, or zero where nine belongs. It also checks that the preset inputs have no effect on the builds that lack the preset.

// File: rtl/ripple_pkg.sv
`timescale 1ns/1ps
package ripple_pkg;

  localparam int HI_W = 3;

  typedef logic [HI_W-1:0] hi_t;

  // Upper-section value that, together with the low bit set, reads decimal nine
  localparam hi_t NINE_HI = 3'b100;

  function automatic hi_t step_by5(hi_t s);
    return (s == 3'd4) ? 3'd0 : s + 3'd1;
  endfunction

  // Divide-by-three pair in the low two bits, top bit toggles on pair wrap
  function automatic hi_t step_by6(hi_t s);
    if (s[1:0] == 2'd2) return {~s[2], 2'b00};
    else                return {s[2], s[1:0] + 2'd1};
  endfunction

  function automatic hi_t step_by8(hi_t s);
    return s + 3'd1;
  endfunction

endpackage

// File: rtl/tally_half.sv
`timescale 1ns/1ps
module tally_half (
  input  logic clk_n,
  input  logic clr,
  input  logic set,
  output logic q
);
  logic q_r;
  logic q_nx;

  always_comb begin
    q_nx = ~q_r;
  end

  always_ff @(negedge clk_n or posedge clr or posedge set) begin
    if (set)      q_r <= 1'b1;
    else if (clr) q_r <= 1'b0;
    else          q_r <= q_nx;
  end

  assign q = q_r;
endmodule

// File: rtl/tally_upper.sv
`timescale 1ns/1ps
module tally_upper #(
  parameter int MODULUS = 5
) (
  input  logic                          clk_n,
  input  logic                          clr,
  input  logic                          set,
  output logic [ripple_pkg::HI_W-1:0]   q
);
  import ripple_pkg::*;

  hi_t hi_r;
  hi_t hi_nx;

  generate
    if (MODULUS == 5) begin : g_by5
      always_comb begin
        hi_nx = step_by5(hi_r);
      end
      // R3: the five-state loop never reaches codes 5..7
      a_r3_legal_code: assert property (@(negedge clk_n) disable iff (clr || set)
        hi_r <= 3'd4);
    end else if (MODULUS == 6) begin : g_by6
      always_comb begin
        hi_nx = step_by6(hi_r);
      end
      // R8: the divide-by-three pair never holds 2'b11
      a_r8_pair_legal: assert property (@(negedge clk_n) disable iff (clr || set)
        hi_r[1:0] != 2'b11);
    end else begin : g_by8
      always_comb begin
        hi_nx = step_by8(hi_r);
      end
    end
  endgenerate

  always_ff @(negedge clk_n or posedge clr or posedge set) begin
    if (set)      hi_r <= NINE_HI;
    else if (clr) hi_r <= '0;
    else          hi_r <= hi_nx;
  end

  assign q = hi_r;
endmodule

// File: rtl/dual_section_counter.sv
`timescale 1ns/1ps
module dual_section_counter #(
  parameter int MODULUS = 5
) (
  input  logic       clk_div2,
  input  logic       clk_upper,
  input  logic       clr_a,
  input  logic       clr_b,
  input  logic       nine_a,
  input  logic       nine_b,
  output logic       out_bit0,
  output logic [2:0] out_hi
);
  localparam bit HAS_NINE = (MODULUS == 5);

  logic clr_act;
  logic set_act;

  always_comb begin
    clr_act = clr_a & clr_b;
    set_act = HAS_NINE & nine_a & nine_b;
  end

  tally_half u_half (
    .clk_n (clk_div2),
    .clr   (clr_act),
    .set   (set_act),
    .q     (out_bit0)
  );

  tally_upper #(.MODULUS(MODULUS)) u_upper (
    .clk_n (clk_upper),
    .clr   (clr_act),
    .set   (set_act),
    .q     (out_hi)
  );

  // R5: a held clear keeps every output at zero
  a_r5_clear_zero: assert property (@(negedge clk_div2) disable iff (set_act)
    clr_act |-> ({out_hi, out_bit0} == 4'd0));

  generate
    if (HAS_NINE) begin : g_nine_chk
      // R6: a held preset shows nine
      a_r6_preset_nine: assert property (@(negedge clk_div2) disable iff (clr_act)
        set_act |-> ({out_hi, out_bit0} == 4'b1001));
      // R6: preset wins over clear
      a_r6_preset_wins: assert property (@(negedge clk_div2) disable iff (!clr_act)
        set_act |-> ({out_hi, out_bit0} == 4'b1001));
    end
  endgenerate
endmodule

// File: tb/dual_section_counter_test.sv
`timescale 1ns/1ps
module dual_section_counter_test;
  logic drv0, drv1;
  logic clr_a, clr_b, nine_a, nine_b;
  logic casc, biq;
  int   n_chk, n_bad;
  bit   done;

  logic       q0_5, q0_6, q0_8;
  logic [2:0] hi_5, hi_6, hi_8;
  logic       cp0_5, cp1_5;

  assign cp0_5 = biq  ? hi_5[2] : drv0;
  assign cp1_5 = casc ? q0_5    : drv1;

  dual_section_counter #(.MODULUS(5)) uut (
    .clk_div2(cp0_5), .clk_upper(cp1_5), .clr_a(clr_a), .clr_b(clr_b),
    .nine_a(nine_a), .nine_b(nine_b), .out_bit0(q0_5), .out_hi(hi_5));

  dual_section_counter #(.MODULUS(6)) uut6 (
    .clk_div2(drv0), .clk_upper(q0_6), .clr_a(clr_a), .clr_b(clr_b),
    .nine_a(nine_a), .nine_b(nine_b), .out_bit0(q0_6), .out_hi(hi_6));

  dual_section_counter #(.MODULUS(8)) uut8 (
    .clk_div2(drv0), .clk_upper(q0_8), .clr_a(clr_a), .clr_b(clr_b),
    .nine_a(nine_a), .nine_b(nine_b), .out_bit0(q0_8), .out_hi(hi_8));

  function automatic int v5(); return int'({hi_5, q0_5}); endfunction
  function automatic int v6(); return int'({hi_6, q0_6}); endfunction
  function automatic int v8(); return int'({hi_8, q0_8}); endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 250 MHz: 2 ns low, 2 ns high
  task automatic pulse0();
    drv0 = 1'b0; #2; drv0 = 1'b1; #2;
  endtask

  task automatic pulse1();
    drv1 = 1'b0; #2; drv1 = 1'b1; #2;
  endtask

  // Hold clear, pick wiring, release clear
  task automatic restart(bit c, bit b);
    clr_a = 1'b1; clr_b = 1'b1; #1;
    casc = c; biq = b; #1;
    clr_a = 1'b0; clr_b = 1'b0; #2;
  endtask

  task automatic t_reset();
    check("R5 reset", v5(), 0);
    check("R5 reset div6", v6(), 0);
    check("R5 reset div8", v8(), 0);
    restart(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) pulse0();
    check("R5 pre-clear count", v5(), 3);
    clr_a = 1'b1; #1;
    check("R5 single clear input ignored", v5(), 3);
    clr_a = 1'b0; clr_b = 1'b1; #1;
    check("R5 single clear input ignored b", v5(), 3);
    clr_a = 1'b1; #1;
    check("R5 clear without clock", v5(), 0);
    clr_a = 1'b0; clr_b = 1'b0; #2;
  endtask

  task automatic t_half();
    restart(1'b0, 1'b0);
    for (int i = 1; i <= 4; i++) begin
      drv0 = 1'b0; #2;
      check("R1 toggle on fall", int'(q0_5), i % 2);
      check("R2 upper untouched by clk_div2", int'(hi_5), 0);
      drv0 = 1'b1; #2;
      check("R1 rising edge ignored", int'(q0_5), i % 2);
    end
  endtask

  task automatic t_upper();
    restart(1'b0, 1'b0);
    for (int i = 1; i <= 7; i++) begin
      drv1 = 1'b0; #2;
      check("R3 div5 step", int'(hi_5), i % 5);
      drv1 = 1'b1; #2;
      check("R2 rising edge ignored", int'(hi_5), i % 5);
      check("R2 low bit untouched", int'(q0_5), 0);
    end
  endtask

  task automatic t_cascade();
    restart(1'b1, 1'b0);
    for (int k = 1; k <= 26; k++) begin
      int idx;
      int e6;
      pulse0();
      check("R3 bcd", v5(), k % 10);
      idx = (k / 2) % 6;
      e6 = (((idx / 3) * 4 + (idx % 3)) * 2) + (k % 2);
      check("R8 divide by 12", v6(), e6);
      check("R9 binary mod 16", v8(), k % 16);
    end
  endtask

  task automatic t_biq();
    restart(1'b0, 1'b1);
    for (int k = 1; k <= 13; k++) begin
      int n;
      pulse1();
      n = k % 10;
      check("R4 biq upper", int'(hi_5), n % 5);
      check("R4 biq msd", int'(q0_5), n / 5);
    end
  endtask

  task automatic t_preset();
    int keep6, keep8;
    restart(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) pulse0();
    keep6 = v6(); keep8 = v8();
    nine_a = 1'b1; #1;
    check("R6 single preset input ignored", v5(), 5);
    nine_a = 1'b0; nine_b = 1'b1; #1;
    check("R6 single preset input ignored b", v5(), 5);
    nine_a = 1'b1; #1;
    check("R6 preset without clock", v5(), 9);
    check("R10 div6 ignores preset", v6(), keep6);
    check("R10 div8 ignores preset", v8(), keep8);
    clr_a = 1'b1; clr_b = 1'b1; #1;
    check("R6 preset wins over clear", v5(), 9);
    clr_a = 1'b0; clr_b = 1'b0; #1;
    nine_a = 1'b0; nine_b = 1'b0; #2;
    pulse0();
    check("R3 wrap from preset nine", v5(), 0);
  endtask

  task automatic t_hold();
    restart(1'b0, 1'b0);
    pulse0(); pulse1();
    clr_a = 1'b1; clr_b = 1'b1; #1;
    for (int i = 0; i < 3; i++) begin pulse0(); pulse1(); end
    check("R7 edges ignored under clear", v5(), 0);
    check("R7 edges ignored under clear div8", v8(), 0);
    clr_a = 1'b0; clr_b = 1'b0; #1;
    nine_a = 1'b1; nine_b = 1'b1; #1;
    for (int i = 0; i < 3; i++) begin pulse0(); pulse1(); end
    check("R7 edges ignored under preset", v5(), 9);
    nine_a = 1'b0; nine_b = 1'b0; #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    drv0 = 1'b1; drv1 = 1'b1; casc = 1'b0; biq = 1'b0;
    nine_a = 1'b0; nine_b = 1'b0;
    clr_a = 1'b1; clr_b = 1'b1;
    #4;
    t_reset();
    t_half();
    t_upper();
    t_cascade();
    t_biq();
    t_preset();
    t_hold();
    finish_run();
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule